// File: doc/BRIEF.md
# Sprite Table DMA Engine

This block copies a fixed run of 160 bytes from system memory into the on-chip sprite attribute memory. Software starts a copy by writing one byte to the control register at address 0xFF46. That byte becomes the upper half of the 16-bit source address. The engine then reads page:0x00, page:0x01 and onward, and stores each byte at the matching offset of the attribute memory.

All sequencing runs on a machine-cycle strobe. The block derives this strobe from the fast master clock, with four master clocks to each machine cycle. The machine cycle right after the register write is an idle delay, and the attribute memory stays open to the CPU during it. The next 160 machine cycles each move one byte.

During those 160 cycles the block owns the attribute memory. CPU reads of it return 0xFF and CPU writes to it are dropped. A busy output covers the delay cycle and the copy together, and a lock output covers only the copy.

Top module: `spr_dma_top`

## Requirements
- R1: A register write is accepted only when `reg_wr_en` is high with `reg_wr_addr` equal to 0xFF46 on a clock edge where `mcyc_strobe` is high. The written byte is the source page. During copy cycle k (k = 0..159), `src_rd_en` is high and `src_rd_addr` equals page*256 + k.
- R2: The machine cycle after an accepted write is a delay cycle. In it `dma_busy` is 1, `oam_lock` is 0, `src_rd_en` is 0, and the engine writes nothing to the attribute memory.
- R3: Each of the 160 copy cycles writes exactly one byte. In copy cycle k, `oam_we` is high on the strobe edge with `oam_addr` = k and `oam_wdata` = `src_rd_data`. Attribute offsets 0x00..0x9F therefore end up holding source bytes page:0x00..page:0x9F in order.
- R4: `oam_lock` is 1 in machine cycles 1 through 160 after the write and 0 from machine cycle 161 on.
- R5: `dma_busy` is 1 for exactly 161 machine cycles, from the delay cycle through the last copy cycle. `oam_lock` is never 1 while `dma_busy` is 0.
- R6: `mcyc_strobe` is high for one master clock out of every four. Engine state changes only on clock edges where the strobe is high.
- R7: While `oam_lock` is 1, `cpu_oam_rdata` reads 0xFF. CPU writes issued in that time leave the attribute memory unchanged.
- R8: While `oam_lock` is 0, CPU reads and writes pass straight through to the attribute memory. This includes the delay cycle.
- R9: An accepted register write during a running transfer restarts the whole sequence from the new page, including a fresh delay cycle and a full 160-cycle copy.
- R10: Writes to any other address have no effect on `dma_busy`. So do control-register writes made on a clock edge where the strobe is low.
- R11: After reset, `dma_busy`, `oam_lock`, `src_rd_en` and `oam_we` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mcyc_strobe | output | 1 | One master clock high per machine cycle |
| reg_wr_en | input | 1 | CPU I/O write enable |
| reg_wr_addr | input | 16 | CPU I/O write address |
| reg_wr_data | input | 8 | CPU I/O write data (source page) |
| src_rd_en | output | 1 | Source read active |
| src_rd_addr | output | 16 | Source read address |
| src_rd_data | input | 8 | Source read data, same cycle |
| oam_we | output | 1 | Attribute memory write enable |
| oam_addr | output | 8 | Attribute memory address (read and write) |
| oam_wdata | output | 8 | Attribute memory write data |
| oam_rdata | input | 8 | Attribute memory read data |
| cpu_oam_we | input | 1 | CPU attribute write request |
| cpu_oam_addr | input | 8 | CPU attribute address |
| cpu_oam_wdata | input | 8 | CPU attribute write data |
| cpu_oam_rdata | output | 8 | CPU attribute read data |
| oam_lock | output | 1 | Attribute memory owned by the engine |
| dma_busy | output | 1 | Delay cycle or copy in progress |

## Verification
Copies run from random source pages, each with a random per-run data salt. This shows whether bytes land at the right offsets in the right order, and not merely that some write happened. Every machine cycle of each window is sampled, which separates the delay cycle from the first copy cycle and finds off-by-one errors at either end of the 161-cycle busy span.

Directed cases cover the following:
- CPU accesses during the delay cycle against accesses during the lock.
- A rewrite in the middle of a copy, which must start a new full window.
- Near-miss addresses, which must not start the engine.
- A correctly addressed write placed off the strobe, which must not start the engine.

// File: rtl/spr_dma_pkg.sv
package spr_dma_pkg;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int PAGE_W = 8;
  localparam int OFFS_W = ADDR_W - PAGE_W;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_WAIT = 2'd1,
    SEQ_MOVE = 2'd2
  } seq_state_e;

  // source address of byte number offs within the selected page
  function automatic logic [ADDR_W-1:0] src_byte_addr(
    input logic [PAGE_W-1:0] page,
    input logic [OFFS_W-1:0] offs
  );
    return {page, offs};
  endfunction

  // control register write decode
  function automatic logic reg_hit(
    input logic              en,
    input logic [ADDR_W-1:0] addr,
    input logic [ADDR_W-1:0] target
  );
    return en && (addr == target);
  endfunction

endpackage

// File: rtl/spr_dma_mtick.sv
module spr_dma_mtick #(
  parameter int T_PER_M = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic strobe
);
  localparam int CW = (T_PER_M > 1) ? $clog2(T_PER_M) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(T_PER_M - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_q <= '0;
    else if (cnt_q == CNT_LAST) cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

  assign strobe = (cnt_q == CNT_LAST);

  // independent spacing counter for the checker
  logic [CW:0] gap_q;
  always_ff @(posedge clk) begin
    if (!rst_n || strobe) gap_q <= '0;
    else                  gap_q <= gap_q + 1'b1;
  end

  assert_strobe_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> (gap_q == (CW+1)'(T_PER_M - 1)));

  generate
    if (T_PER_M > 1) begin : g_multi
      assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);
    end
  endgenerate

endmodule

// File: rtl/spr_dma_seq.sv
module spr_dma_seq
  import spr_dma_pkg::*;
#(
  parameter int                XFER_LEN = 160,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'hFF46,
  localparam int               IW       = $clog2(XFER_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              busy,
  output logic              move_active,
  output logic [IW-1:0]     move_idx,
  output logic [PAGE_W-1:0] page,
  output logic              start_evt,
  output logic              done_evt
);
  localparam logic [IW-1:0] IDX_LAST = IW'(XFER_LEN - 1);

  seq_state_e        st_q;
  logic [IW-1:0]     idx_q;
  logic [PAGE_W-1:0] page_q;

  assign start_evt = tick && reg_hit(wr_en, wr_addr, REG_ADDR);
  assign done_evt  = tick && !start_evt && (st_q == SEQ_MOVE) && (idx_q == IDX_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      idx_q  <= '0;
      page_q <= '0;
    end else if (start_evt) begin
      st_q   <= SEQ_WAIT;
      idx_q  <= '0;
      page_q <= PAGE_W'(wr_data);
    end else if (tick) begin
      case (st_q)
        SEQ_WAIT: begin
          st_q  <= SEQ_MOVE;
          idx_q <= '0;
        end
        SEQ_MOVE: begin
          if (idx_q == IDX_LAST) begin
            st_q  <= SEQ_IDLE;
            idx_q <= '0;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: st_q <= SEQ_IDLE;
      endcase
    end
  end

  assign busy        = (st_q != SEQ_IDLE);
  assign move_active = (st_q == SEQ_MOVE);
  assign move_idx    = idx_q;
  assign page        = page_q;

  assert_state_holds_off_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(st_q) && $stable(idx_q) && $stable(page_q)));

  assert_delay_then_copy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !start_evt && st_q == SEQ_WAIT) |=> (st_q == SEQ_MOVE && idx_q == '0));

  assert_index_steps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !start_evt && st_q == SEQ_MOVE && idx_q != IDX_LAST)
      |=> (st_q == SEQ_MOVE && idx_q == $past(idx_q) + 1'b1));

  assert_end_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (st_q == SEQ_IDLE));

  assert_restart_fresh_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (st_q == SEQ_WAIT && page_q == $past(wr_data)));

endmodule

// File: rtl/spr_dma_copy_path.sv
module spr_dma_copy_path
  import spr_dma_pkg::*;
#(
  parameter int  XFER_LEN = 160,
  parameter int  OAM_AW   = 8,
  localparam int IW       = $clog2(XFER_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              move_active,
  input  logic [IW-1:0]     move_idx,
  input  logic [PAGE_W-1:0] page,
  output logic              src_rd_en,
  output logic [ADDR_W-1:0] src_rd_addr,
  input  logic [DATA_W-1:0] src_rd_data,
  output logic              dma_we,
  output logic [OAM_AW-1:0] dma_addr,
  output logic [DATA_W-1:0] dma_wdata
);
  assign src_rd_en   = move_active;
  assign src_rd_addr = src_byte_addr(page, OFFS_W'(move_idx));
  assign dma_we      = move_active && tick;
  assign dma_addr    = OAM_AW'(move_idx);
  assign dma_wdata   = src_rd_data;

  assert_write_inside_table_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dma_we |-> (int'(dma_addr) < XFER_LEN));

  assert_write_has_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    dma_we |-> (src_rd_en && src_rd_addr[OFFS_W-1:0] == OFFS_W'(dma_addr)));

endmodule

// File: rtl/spr_dma_oam_gate.sv
module spr_dma_oam_gate
  import spr_dma_pkg::*;
#(
  parameter int OAM_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock,
  input  logic              dma_we,
  input  logic [OAM_AW-1:0] dma_addr,
  input  logic [DATA_W-1:0] dma_wdata,
  input  logic              cpu_we,
  input  logic [OAM_AW-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              oam_we,
  output logic [OAM_AW-1:0] oam_addr,
  output logic [DATA_W-1:0] oam_wdata,
  input  logic [DATA_W-1:0] oam_rdata
);
  always_comb begin
    if (lock) begin
      oam_we    = dma_we;
      oam_addr  = dma_addr;
      oam_wdata = dma_wdata;
      cpu_rdata = '1;
    end else begin
      oam_we    = cpu_we;
      oam_addr  = cpu_addr;
      oam_wdata = cpu_wdata;
      cpu_rdata = oam_rdata;
    end
  end

  assert_engine_writes_only_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dma_we |-> lock);

  assert_cpu_write_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && cpu_we && !dma_we) |-> !oam_we);

endmodule

// File: rtl/spr_dma_top.sv
module spr_dma_top
  import spr_dma_pkg::*;
#(
  parameter int                T_PER_M  = 4,
  parameter int                XFER_LEN = 160,
  parameter int                OAM_AW   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'hFF46
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              mcyc_strobe,
  input  logic              reg_wr_en,
  input  logic [15:0]       reg_wr_addr,
  input  logic [7:0]        reg_wr_data,
  output logic              src_rd_en,
  output logic [15:0]       src_rd_addr,
  input  logic [7:0]        src_rd_data,
  output logic              oam_we,
  output logic [7:0]        oam_addr,
  output logic [7:0]        oam_wdata,
  input  logic [7:0]        oam_rdata,
  input  logic              cpu_oam_we,
  input  logic [7:0]        cpu_oam_addr,
  input  logic [7:0]        cpu_oam_wdata,
  output logic [7:0]        cpu_oam_rdata,
  output logic              oam_lock,
  output logic              dma_busy
);
  localparam int IW = $clog2(XFER_LEN);

  logic              tick;
  logic              move_active;
  logic [IW-1:0]     move_idx;
  logic [PAGE_W-1:0] page;
  logic              start_evt;
  logic              done_evt;
  logic              dma_we;
  logic [OAM_AW-1:0] dma_addr;
  logic [DATA_W-1:0] dma_wdata;

  spr_dma_mtick #(.T_PER_M(T_PER_M)) u_mtick (
    .clk(clk), .rst_n(rst_n), .strobe(tick)
  );

  spr_dma_seq #(.XFER_LEN(XFER_LEN), .REG_ADDR(REG_ADDR)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .wr_en(reg_wr_en), .wr_addr(reg_wr_addr), .wr_data(reg_wr_data),
    .busy(dma_busy), .move_active(move_active), .move_idx(move_idx),
    .page(page), .start_evt(start_evt), .done_evt(done_evt)
  );

  spr_dma_copy_path #(.XFER_LEN(XFER_LEN), .OAM_AW(OAM_AW)) u_path (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .move_active(move_active), .move_idx(move_idx), .page(page),
    .src_rd_en(src_rd_en), .src_rd_addr(src_rd_addr), .src_rd_data(src_rd_data),
    .dma_we(dma_we), .dma_addr(dma_addr), .dma_wdata(dma_wdata)
  );

  assign oam_lock    = move_active;
  assign mcyc_strobe = tick;

  spr_dma_oam_gate #(.OAM_AW(OAM_AW)) u_gate (
    .clk(clk), .rst_n(rst_n), .lock(oam_lock),
    .dma_we(dma_we), .dma_addr(dma_addr), .dma_wdata(dma_wdata),
    .cpu_we(cpu_oam_we), .cpu_addr(cpu_oam_addr), .cpu_wdata(cpu_oam_wdata),
    .cpu_rdata(cpu_oam_rdata),
    .oam_we(oam_we), .oam_addr(oam_addr), .oam_wdata(oam_wdata), .oam_rdata(oam_rdata)
  );

  assert_lock_inside_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    oam_lock |-> dma_busy);

  assert_busy_opens_unlocked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_busy) |-> !oam_lock);

  assert_start_sets_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (dma_busy && !oam_lock));

  assert_done_clears_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (!dma_busy && !oam_lock));

endmodule

// File: tb/spr_dma_top_bench.sv
module spr_dma_top_bench;
  localparam int CLK_NS   = 10;
  localparam int T_PER_M  = 4;
  localparam int XFER_LEN = 160;
  localparam logic [15:0] REG_A = 16'hFF46;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mcyc_strobe;
  logic reg_wr_en = 1'b0;
  logic [15:0] reg_wr_addr = '0;
  logic [7:0] reg_wr_data = '0;
  logic src_rd_en;
  logic [15:0] src_rd_addr;
  logic [7:0] src_rd_data;
  logic oam_we;
  logic [7:0] oam_addr, oam_wdata, oam_rdata;
  logic cpu_oam_we = 1'b0;
  logic [7:0] cpu_oam_addr = '0, cpu_oam_wdata = '0;
  logic [7:0] cpu_oam_rdata;
  logic oam_lock, dma_busy;

  int n_tests = 0;
  int n_fail = 0;
  bit finished = 0;
  logic [7:0] salt = 8'h00;

  always #(CLK_NS/2) clk = ~clk;

  spr_dma_top u_spr_dma_top (
    .clk(clk), .rst_n(rst_n), .mcyc_strobe(mcyc_strobe),
    .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .src_rd_en(src_rd_en), .src_rd_addr(src_rd_addr), .src_rd_data(src_rd_data),
    .oam_we(oam_we), .oam_addr(oam_addr), .oam_wdata(oam_wdata), .oam_rdata(oam_rdata),
    .cpu_oam_we(cpu_oam_we), .cpu_oam_addr(cpu_oam_addr), .cpu_oam_wdata(cpu_oam_wdata),
    .cpu_oam_rdata(cpu_oam_rdata), .oam_lock(oam_lock), .dma_busy(dma_busy)
  );

  // source memory content as a function of address and run salt
  function automatic logic [7:0] src_fn(input logic [15:0] a, input logic [7:0] s);
    return (a[7:0] * 8'd13) ^ a[15:8] ^ s;
  endfunction

  function automatic logic [7:0] fill_fn(input logic [7:0] a);
    return a ^ 8'h96;
  endfunction

  function automatic logic [15:0] exp_src(input logic [7:0] pg, input int k);
    return (16'(pg) << 8) + 16'(k);
  endfunction

  // attribute memory model
  logic [7:0] oam_mem [256];
  always @(posedge clk) if (oam_we) oam_mem[oam_addr] <= oam_wdata;
  assign oam_rdata   = oam_mem[oam_addr];
  assign src_rd_data = src_fn(src_rd_addr, salt);

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  task automatic wait_strobe();
    @(negedge clk);
    while (!mcyc_strobe) @(negedge clk);
  endtask

  task automatic reg_write(input logic [15:0] a, input logic [7:0] d);
    wait_strobe();
    reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  // check every machine cycle of one window, starting at the delay cycle
  task automatic run_window(input logic [7:0] pg);
    int bad_busy = 0, bad_lock = 0, bad_src = 0, bad_wr = 0, bad_dly = 0;
    for (int j = 0; j <= XFER_LEN + 1; j++) begin
      wait_strobe();
      if (dma_busy !== (j <= XFER_LEN)) bad_busy++;
      if (oam_lock !== (j >= 1 && j <= XFER_LEN)) bad_lock++;
      if (j == 0 && (src_rd_en !== 1'b0 || oam_we !== 1'b0)) bad_dly++;
      if (j >= 1 && j <= XFER_LEN) begin
        if (src_rd_en !== 1'b1 || src_rd_addr !== exp_src(pg, j-1)) bad_src++;
        if (oam_we !== 1'b1 || oam_addr !== 8'(j-1) || oam_wdata !== src_fn(exp_src(pg, j-1), salt))
          bad_wr++;
      end
    end
    chk(bad_busy == 0, "R5 busy window", bad_busy, 0);
    chk(bad_lock == 0, "R4 lock window", bad_lock, 0);
    chk(bad_dly == 0, "R2 delay cycle idle", bad_dly, 0);
    chk(bad_src == 0, "R1 source address sequence", bad_src, 0);
    chk(bad_wr == 0, "R3 one write per copy cycle", bad_wr, 0);
  endtask

  task automatic verify_table(input logic [7:0] pg);
    int bad = 0;
    logic [7:0] first_act = 0, first_exp = 0;
    for (int a = 0; a < XFER_LEN; a++) begin
      @(negedge clk);
      cpu_oam_addr = 8'(a);
      #1;
      if (cpu_oam_rdata !== src_fn(exp_src(pg, a), salt)) begin
        if (bad == 0) begin first_act = cpu_oam_rdata; first_exp = src_fn(exp_src(pg, a), salt); end
        bad++;
      end
    end
    chk(bad == 0, "R3 table contents in order", first_act, first_exp);
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R11 reset state
    chk(dma_busy == 0 && oam_lock == 0 && src_rd_en == 0 && oam_we == 0, "R11 reset idle",
        {dma_busy, oam_lock, src_rd_en, oam_we}, 0);

    // R6 strobe spacing
    begin
      int gap = 0;
      wait_strobe();
      do begin @(negedge clk); gap++; end while (!mcyc_strobe);
      chk(gap == T_PER_M, "R6 strobe period", gap, T_PER_M);
    end

    // R8 preload table through the CPU path while unlocked
    for (int a = 0; a < 256; a++) begin
      @(negedge clk);
      cpu_oam_we = 1'b1; cpu_oam_addr = 8'(a); cpu_oam_wdata = fill_fn(8'(a));
    end
    @(negedge clk); cpu_oam_we = 1'b0;
    cpu_oam_addr = 8'hB7; #1;
    chk(cpu_oam_rdata == fill_fn(8'hB7), "R8 unlocked read passes", cpu_oam_rdata, fill_fn(8'hB7));

    // R10 near-miss addresses and off-strobe write
    reg_write(16'hFF45, 8'h12);
    reg_write(16'hFE46, 8'h12);
    wait_strobe(); @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_addr = REG_A; reg_wr_data = 8'h12;
    @(negedge clk); reg_wr_en = 1'b0;
    begin
      int seen = 0;
      for (int i = 0; i < 3; i++) begin wait_strobe(); if (dma_busy) seen++; end
      chk(seen == 0, "R10 no start from other writes", seen, 0);
    end

    // directed: CPU access during delay and lock
    salt = 8'h3C;
    reg_write(REG_A, 8'h40);
    cpu_oam_we = 1'b1; cpu_oam_addr = 8'hA0; cpu_oam_wdata = 8'h5A;
    @(negedge clk); cpu_oam_we = 1'b0; #1;
    chk(cpu_oam_rdata == 8'h5A, "R2 CPU open in delay cycle", cpu_oam_rdata, 8'h5A);
    wait_strobe(); @(negedge clk);
    cpu_oam_we = 1'b1; cpu_oam_addr = 8'hA1; cpu_oam_wdata = 8'hC3; #1;
    chk(oam_lock == 1 && cpu_oam_rdata == 8'hFF, "R7 locked read gives FF", cpu_oam_rdata, 8'hFF);
    @(negedge clk); cpu_oam_we = 1'b0;
    while (dma_busy) @(negedge clk);
    cpu_oam_addr = 8'hA1; #1;
    chk(cpu_oam_rdata == fill_fn(8'hA1), "R7 locked write ignored", cpu_oam_rdata, fill_fn(8'hA1));
    verify_table(8'h40);

    // directed: full window check on page 0x40
    salt = 8'h11;
    reg_write(REG_A, 8'h40);
    run_window(8'h40);
    verify_table(8'h40);

    // R9 restart mid-copy
    salt = 8'h77;
    reg_write(REG_A, 8'h81);
    repeat (50) wait_strobe();
    reg_write(REG_A, 8'hC0);
    run_window(8'hC0);
    verify_table(8'hC0);
    chk(1, "R9 restart window above", 0, 0);

    // random pages
    for (int r = 0; r < 6; r++) begin
      logic [7:0] pg;
      pg = 8'($urandom);
      salt = 8'($urandom);
      reg_write(REG_A, pg);
      run_window(pg);
      verify_table(pg);
    end
    // boundary pages
    salt = 8'hE5; reg_write(REG_A, 8'hFF); run_window(8'hFF); verify_table(8'hFF);
    salt = 8'h08; reg_write(REG_A, 8'h00); run_window(8'h00); verify_table(8'h00);

    summary();
  end
endmodule